// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block works out the column address of every data beat in a double-data-rate SDRAM burst. A read or write command supplies a start column. The block then steps through the burst using the mode it holds: burst length 2, 4 or 8, sequential or interleaved wrap order, and a CAS latency of 2 or 2.5 clocks. Two beats move per clock, so each cycle presents an even-beat column and an odd-beat column together. A burst of length BL therefore takes BL/2 cycles.

The mode is loaded by a mode-set strobe carrying a bank field and an address word. A read burst can be cut short by a stop strobe, or replaced by a new command. A write burst cannot be stopped. For reads, a two-slot window marks the half clocks in which read data would be on the bus, which is the read beat activity delayed by the CAS latency counted in half clocks. A mode-set that requests a DLL reset produces a one-cycle pulse.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset `beat_valid`, `beat_last`, `beat_write`, `rd_win`, `dll_reset_pulse` and `mode_err` are 0. The mode is burst length 2, sequential order and CAS latency 2.
- R2: A mode-set is taken only when `mrs_valid` is 1 and `mrs_bank` is 2'b00. The field positions in `mrs_addr` are: bits [2:0] burst length (1=2, 2=4, 3=8), bit 3 order (0 sequential, 1 interleaved), bits [6:4] latency (2=CL2, 6=CL2.5). A mode-set with a nonzero bank changes nothing.
- R3: A taken mode-set with an illegal burst-length or latency code leaves the whole mode unchanged and sets `mode_err`. `mode_err` stays 1 until reset.
- R4: A taken mode-set with `mrs_addr[8]`=1 makes `dll_reset_pulse` 1 for exactly the next cycle. With a nonzero bank, no pulse is produced.
- R5: The cycle after `cmd_valid`, `beat_valid` is 1 and carries beats 0 and 1. Beats 2k and 2k+1 follow in the k-th cycle after that. The burst lasts BL/2 cycles, with `beat_last` marking the final pair. The burst length and order are the ones in force when the command was taken.
- R6: In sequential order, beat b uses low bits (start_low + b) mod BL. Here start_low is the low log2(BL) bits of the start column. Higher column bits are unchanged.
- R7: In interleaved order, beat b uses low bits start_low XOR b. Higher column bits are unchanged.
- R8: `stop_valid` during a read burst makes `beat_valid` 0 from the next cycle. `stop_valid` while idle has no effect.
- R9: `stop_valid` during a write burst is ignored, and the burst runs to its full length.
- R10: `cmd_valid` during a running burst restarts at the new column with beat 0 in the next cycle.
- R11: Let H be the latency in half clocks (4 for CL2, 5 for CL2.5). `rd_win[0]` (first half of a clock) equals the read-beat activity ceil(H/2) cycles earlier. `rd_win[1]` (second half) equals it floor(H/2) cycles earlier. Write beats never open the window.
- R12: `beat_write` is 1 exactly when `beat_valid` is 1 and the running burst is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_valid | input | 1 | Mode-set strobe |
| mrs_bank | input | 2 | Bank field of the mode-set |
| mrs_addr | input | ADDR_W | Mode word |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_col | input | COL_W | Start column |
| stop_valid | input | 1 | Burst-stop strobe |
| beat_col_even | output | COL_W | Column of the even beat this cycle |
| beat_col_odd | output | COL_W | Column of the odd beat this cycle |
| beat_valid | output | 1 | A beat pair is presented |
| beat_last | output | 1 | This pair ends the burst |
| beat_write | output | 1 | Current pair belongs to a write |
| rd_win | output | 2 | Read data window per half clock |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| mode_err | output | 1 | Sticky illegal mode code flag |

## Verification
The bench walks every start offset for all three burst lengths in both orders, at both latencies. A mistake in the wrap arithmetic would show up as a column that runs out of its aligned block, or as swapped sequential and interleaved patterns. It stops a read and a write mid-burst and restarts a burst early. A design that stopped writes, ignored read stops, or kept the old burst counter would emit too many or too few pairs. It compares the half-clock window at CL2.5, where an off-by-one-half error would shift only one of the two slots. It also loads a nonzero bank, illegal codes, and the DLL bit, checking that the mode is kept, the error flag sticks, and the pulse lasts one cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int OFF_W  = 3;
  localparam int PAIR_W = 2;

  typedef enum logic [1:0] {BL_2 = 2'd0, BL_4 = 2'd1, BL_8 = 2'd2} blen_e;

  typedef struct packed {
    blen_e      blen;
    logic       ilv;
    logic [2:0] lat_half;
  } mode_t;

  function automatic logic [OFF_W-1:0] off_mask(blen_e b);
    case (b)
      BL_2:    return 3'b001;
      BL_4:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [PAIR_W-1:0] last_pair(blen_e b);
    case (b)
      BL_2:    return 2'd0;
      BL_4:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] beat_off(logic [OFF_W-1:0] low,
                                                logic [OFF_W-1:0] beat,
                                                blen_e b, logic ilv);
    logic [OFF_W-1:0] m;
    m = off_mask(b);
    return ilv ? ((low ^ beat) & m) : ((low + beat) & m);
  endfunction
endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_valid,
  input  logic [1:0]        mrs_bank,
  input  logic [ADDR_W-1:0] mrs_addr,
  output mode_t             mode,
  output logic              err,
  output logic              dll_pulse
);
  logic  sel, bl_ok, lat_ok;
  mode_t new_mode;

  assign sel = mrs_valid && (mrs_bank == 2'b00);

  always_comb begin
    new_mode = mode;
    bl_ok    = 1'b1;
    lat_ok   = 1'b1;
    case (mrs_addr[2:0])
      3'd1:    new_mode.blen = BL_2;
      3'd2:    new_mode.blen = BL_4;
      3'd3:    new_mode.blen = BL_8;
      default: bl_ok = 1'b0;
    endcase
    new_mode.ilv = mrs_addr[3];
    case (mrs_addr[6:4])
      3'd2:    new_mode.lat_half = 3'd4;
      3'd6:    new_mode.lat_half = 3'd5;
      default: lat_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '{blen: BL_2, ilv: 1'b0, lat_half: 3'd4};
      err       <= 1'b0;
      dll_pulse <= 1'b0;
    end else begin
      dll_pulse <= sel && mrs_addr[8];
      if (sel) begin
        if (bl_ok && lat_ok) mode <= new_mode;
        else                 err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bseq_col_gen.sv
module bseq_col_gen
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_t            mode,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             stop_valid,
  output logic [COL_W-1:0] col_even,
  output logic [COL_W-1:0] col_odd,
  output logic             valid,
  output logic             last,
  output logic             write
);
  localparam int HI_W = COL_W - OFF_W;

  logic              act_q, act_d, wr_q, wr_d, ilv_q, ilv_d;
  logic [PAIR_W-1:0] k_q, k_d;
  logic [COL_W-1:0]  start_q, start_d;
  blen_e             blen_q, blen_d;
  logic [COL_W-1:0]  col_q [2];

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    ilv_d   = ilv_q;
    k_d     = k_q;
    start_d = start_q;
    blen_d  = blen_q;
    if (cmd_valid) begin
      act_d   = 1'b1;
      wr_d    = cmd_write;
      start_d = cmd_col;
      k_d     = '0;
      blen_d  = mode.blen;
      ilv_d   = mode.ilv;
    end else if (act_q) begin
      if ((stop_valid && !wr_q) || (k_q == last_pair(blen_q))) act_d = 1'b0;
      else                                                      k_d   = k_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      ilv_q   <= 1'b0;
      k_q     <= '0;
      start_q <= '0;
      blen_q  <= BL_2;
      valid   <= 1'b0;
      last    <= 1'b0;
      write   <= 1'b0;
    end else begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      ilv_q   <= ilv_d;
      k_q     <= k_d;
      start_q <= start_d;
      blen_q  <= blen_d;
      valid   <= act_d;
      last    <= act_d && (k_d == last_pair(blen_d));
      write   <= act_d && wr_d;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_beat
    logic [OFF_W-1:0] off;
    assign off = beat_off(start_d[OFF_W-1:0], {k_d, 1'(i)}, blen_d, ilv_d);
    always_ff @(posedge clk) begin
      if (rst) col_q[i] <= '0;
      else     col_q[i] <= (start_d & ~{{HI_W{1'b0}}, off_mask(blen_d)})
                           | {{HI_W{1'b0}}, off};
    end
  end

  assign col_even = col_q[0];
  assign col_odd  = col_q[1];
endmodule

// File: rtl/bseq_lat_pipe.sv
module bseq_lat_pipe #(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       act_rd,
  input  logic [2:0] lat_half,
  output logic [1:0] win
);
  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH:0]   ext;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[DEPTH-2:0], act_rd};
  end

  assign ext = {pipe_q, act_rd};

  for (genvar i = 0; i < 2; i++) begin : g_slot
    logic [3:0] dsel;
    assign dsel = ({1'b0, lat_half} + 4'((i == 0) ? 1 : 0)) >> 1;
    always_comb begin
      win[i] = 1'b0;
      for (int n = 0; n <= DEPTH; n++)
        if (int'(dsel) == n) win[i] = ext[n];
    end
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import bseq_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int LAT_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_valid,
  input  logic [1:0]        mrs_bank,
  input  logic [ADDR_W-1:0] mrs_addr,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              stop_valid,
  output logic [COL_W-1:0]  beat_col_even,
  output logic [COL_W-1:0]  beat_col_odd,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              beat_write,
  output logic [1:0]        rd_win,
  output logic              dll_reset_pulse,
  output logic              mode_err
);
  mode_t mode;

  bseq_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mrs_bank(mrs_bank),
    .mrs_addr(mrs_addr), .mode(mode), .err(mode_err), .dll_pulse(dll_reset_pulse)
  );

  bseq_col_gen #(.COL_W(COL_W)) u_gen (
    .clk(clk), .rst(rst), .mode(mode), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_col(cmd_col), .stop_valid(stop_valid),
    .col_even(beat_col_even), .col_odd(beat_col_odd), .valid(beat_valid),
    .last(beat_last), .write(beat_write)
  );

  bseq_lat_pipe #(.DEPTH(LAT_DEPTH)) u_lat (
    .clk(clk), .rst(rst), .act_rd(beat_valid && !beat_write),
    .lat_half(mode.lat_half), .win(rd_win)
  );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              mrs_valid,
  input logic [1:0]        mrs_bank,
  input logic [ADDR_W-1:0] mrs_addr,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [COL_W-1:0]  cmd_col,
  input logic              stop_valid,
  input logic [COL_W-1:0]  beat_col_even,
  input logic              beat_valid,
  input logic              beat_last,
  input logic              beat_write,
  input logic              dll_reset_pulse,
  input logic              mode_err
);
  AST_CMD_STARTS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> beat_valid); // R5
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid); // R5
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    beat_last && !cmd_valid |=> !beat_valid); // R5
  AST_FIRST_COL: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> beat_col_even == $past(cmd_col)); // R6
  AST_STOP_READ: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_write && stop_valid && !cmd_valid |=> !beat_valid); // R8
  AST_NO_WRITE_STOP: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_write && !beat_last && stop_valid && !cmd_valid |=> beat_valid); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode_err |=> mode_err); // R3
  AST_DLL_SOURCE: assert property (@(posedge clk) disable iff (rst)
    dll_reset_pulse |-> $past(mrs_valid && mrs_bank == 2'b00 && mrs_addr[8])); // R4
  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (rst)
    beat_write |-> beat_valid); // R12
endmodule

bind sdram_burst_seq bseq_chk #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  logic        clk = 0, rst = 1;
  logic        mrs_valid = 0, cmd_valid = 0, cmd_write = 0, stop_valid = 0;
  logic [1:0]  mrs_bank = 0;
  logic [12:0] mrs_addr = 0;
  logic [9:0]  cmd_col = 0;
  logic [9:0]  beat_col_even, beat_col_odd;
  logic        beat_valid, beat_last, beat_write, dll_reset_pulse, mode_err;
  logic [1:0]  rd_win;

  int checks = 0, fails = 0;
  bit done = 0;
  // reference model state
  int m_bl = 2, m_ilv = 0, m_half = 4, m_err = 0, m_dll = 0;
  int b_act = 0, b_wr = 0, b_start = 0, b_k = 0, b_bl = 2, b_ilv = 0;
  int hist[8];

  sdram_burst_seq i_sdram_burst_seq (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expcol(int start, int bl, int ilv, int b);
    int low = start % bl;
    int hi  = start - low;
    return hi + (ilv ? (low ^ b) : ((low + b) % bl));
  endfunction

  task automatic model();
    if (cmd_valid) begin
      b_act = 1; b_wr = cmd_write; b_start = cmd_col; b_k = 0; b_bl = m_bl; b_ilv = m_ilv;
    end else if (b_act) begin
      if ((stop_valid && !b_wr) || b_k == b_bl/2 - 1) b_act = 0;
      else b_k++;
    end
    m_dll = mrs_valid && mrs_bank == 0 && mrs_addr[8];
    if (mrs_valid && mrs_bank == 0) begin
      int blc = mrs_addr[2:0], lc = mrs_addr[6:4];
      if ((blc >= 1 && blc <= 3) && (lc == 2 || lc == 6)) begin
        m_bl = 1 << blc; m_ilv = mrs_addr[3]; m_half = (lc == 2) ? 4 : 5;
      end else m_err = 1;
    end
    for (int n = 7; n > 0; n--) hist[n] = hist[n-1];
    hist[0] = b_act && !b_wr;
  endtask

  task automatic compare();
    chk("R5 beat_valid", beat_valid, b_act);
    chk("R5 beat_last", beat_last, b_act && b_k == b_bl/2 - 1);
    if (b_act) begin
      chk(b_ilv ? "R7 even col" : "R6 even col", beat_col_even, expcol(b_start, b_bl, b_ilv, 2*b_k));
      chk(b_ilv ? "R7 odd col" : "R6 odd col", beat_col_odd, expcol(b_start, b_bl, b_ilv, 2*b_k+1));
    end
    chk("R12 beat_write", beat_write, b_act && b_wr);
    chk("R11 rd_win first half", rd_win[0], hist[(m_half+1)/2]);
    chk("R11 rd_win second half", rd_win[1], hist[m_half/2]);
    chk("R4 dll pulse", dll_reset_pulse, m_dll);
    chk("R3 mode_err", mode_err, m_err);
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    mrs_valid = 0; cmd_valid = 0; stop_valid = 0; mrs_bank = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int mcode(int bl, int ilv, int half);
    return (bl == 2 ? 1 : bl == 4 ? 2 : 3) | (ilv << 3) | ((half == 4 ? 2 : 6) << 4);
  endfunction

  task automatic do_mrs(int bank, int addr);
    mrs_valid = 1; mrs_bank = 2'(bank); mrs_addr = 13'(addr); step();
  endtask

  task automatic do_cmd(int wr, int col);
    cmd_valid = 1; cmd_write = 1'(wr); cmd_col = 10'(col); step();
  endtask

  initial begin
    for (int n = 0; n < 8; n++) hist[n] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: idle outputs after reset
    chk("R1 valid after reset", beat_valid, 0);
    chk("R1 last after reset", beat_last, 0);
    chk("R1 write after reset", beat_write, 0);
    chk("R1 window after reset", rd_win, 0);
    chk("R1 dll after reset", dll_reset_pulse, 0);
    chk("R1 err after reset", mode_err, 0);
    // R1: default mode is BL2 sequential CL2
    do_cmd(0, 10'h005);
    idle(5);
    // R6 R7 R11: every offset, every length, both orders, both latencies
    for (int half = 4; half <= 5; half++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int bl = 2; bl <= 8; bl *= 2) begin
          do_mrs(0, mcode(bl, ilv, half));
          for (int off = 0; off < bl; off++) begin
            do_cmd(off == 1, 10'h2A8 | off);
            idle(bl/2 + 4);
          end
        end
    // R10: restart during a burst, then back to back
    do_mrs(0, mcode(8, 0, 5));
    do_cmd(0, 10'h100);
    idle(1);
    do_cmd(0, 10'h3F5);
    do_cmd(1, 10'h00E);
    idle(7);
    // R8: stop a read mid-burst; stop while idle
    do_cmd(0, 10'h20B);
    idle(1);
    stop_valid = 1; step();
    idle(5);
    stop_valid = 1; step();
    idle(2);
    // R9: stop during a write is ignored
    do_cmd(1, 10'h011);
    stop_valid = 1; step();
    idle(6);
    // R2: nonzero bank ignored, old BL8 mode stays
    do_mrs(1, mcode(2, 1, 4));
    do_cmd(0, 10'h0C3);
    idle(8);
    // R3: illegal codes keep mode and latch error
    do_mrs(0, 5 | (2 << 4));
    do_mrs(0, 2 | (3 << 4));
    do_cmd(0, 10'h0C6);
    idle(8);
    // R4: DLL reset bit, legal mode; nonzero bank gives no pulse
    do_mrs(0, mcode(4, 1, 4) | 256);
    idle(1);
    do_mrs(2, 256);
    do_cmd(0, 10'h1F3);
    idle(6);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule